// File: doc/BRIEF.md
# Byte-Serial Line Transmitter with Enable, Stop and Restart Gating

This block turns a stream of bytes into a single serial output line. Bytes arrive over a valid/ready handshake and wait in a small first-in first-out store. A shift register sends each byte least significant bit first, one bit for every pulse of a serial-clock enable. When the line has nothing to send it rests at logic high. After a run of bytes has fully left the shift register and the store is empty, a one-cycle completion pulse is raised.

Two separate controls can halt the transmitter. The first is a level enable input. The second is a pair of one-cycle command pulses, halt and resume, which keep a halted state inside the block. The transmitter runs only while the enable is high and no halt is in force. If either control turns it off, the block empties the store and the shift register on the next system clock edge, whether or not serial-clock pulses are arriving, and drives the line high. Bits that were still waiting in the shift register are never sent, and no completion pulse follows an abort.

Top module: `sertx_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `txd` is 1, `frame_done` is 0, the store is empty and the transmitter is not halted. With `tx_en` high, `in_ready` is therefore 1.
- R2: On a `bit_tick` that finds the shift register empty and the store non-empty, the oldest byte is loaded and its bit 0 appears on `txd` after that edge. Each later `bit_tick` presents the next higher bit. Between ticks `txd` does not change.
- R3: `txd` is 1 whenever no byte is being shifted.
- R4: `frame_done` is a one-cycle pulse after the `bit_tick` that finds both the shift register and the store empty following a normal transfer. It coincides with `txd` returning to 1. It is not raised between bytes sent back to back.
- R5: `in_ready` is 1 only when `tx_en` is 1, the block is not halted, no halt command is present in that cycle, and the store (default depth 4) is not full.
- R6: If `tx_en` is 0 at a clock edge, the store and the shift register are emptied at that edge and `txd` is 1 after it, even with no `bit_tick`. Bits that were not yet sent are never sent, and no `frame_done` follows.
- R7: A `cmd_stop` pulse aborts in the same way as R6 and leaves the block halted. The halt persists across changes of `tx_en`.
- R8: A `cmd_restart` pulse clears the halt from the next cycle on. Transmission resumes once the halt is clear and `tx_en` is 1. If `cmd_stop` and `cmd_restart` arrive in the same cycle, the halt is kept.
- R9: A byte offered while `in_ready` is 0 is dropped and is never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable level |
| cmd_stop | input | 1 | One-cycle halt command |
| cmd_restart | input | 1 | One-cycle resume command |
| bit_tick | input | 1 | Serial clock enable, one bit per pulse |
| in_data | input | 8 | Byte to be sent |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Byte accepted when `in_valid` is also 1 |
| txd | output | 1 | Serial output line, idle high |
| frame_done | output | 1 | Pulse when a run of bytes has been sent completely |

## Verification
The hardest situation to reach from the ports is an abort that lands while the store and the shift register are both partly full. Only then can the test show that the leftover bits are discarded and not delayed until later. The stimulus loads two all-zero bytes, which make any leaked bit visible as a 0, and sends three bits of the first. It then drops the enable or pulses the halt on a cycle with no serial tick. After that it sends many ticks and expects a constant high line with no completion pulse. Mixed orderings of the halt, resume and enable controls, including a halt and a resume in the same cycle, check that the halt state lasts exactly as long as required.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // run gate shared by the controller and the checker documentation
  function automatic logic gate_open(input logic en, input logic halted, input logic halt_cmd);
    return en & ~halted & ~halt_cmd;
  endfunction
endpackage

// File: rtl/sertx_gate.sv
module sertx_gate
  import sertx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic cmd_stop,
  input  logic cmd_restart,
  output logic run
);
  logic halted_q;

  // halt wins over a resume that arrives in the same cycle
  always_ff @(posedge clk) begin
    if (rst)              halted_q <= 1'b0;
    else if (cmd_stop)    halted_q <= 1'b1;
    else if (cmd_restart) halted_q <= 1'b0;
  end

  assign run = gate_open(tx_en, halted_q, cmd_stop);
endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so that a RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rptr];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort,
  input  logic         tick,
  input  logic         have,
  input  logic [W-1:0] ld_data,
  output logic         take,
  output logic         txd,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] left;
  logic          busy;

  assign take = tick & ~abort & (left == '0) & have;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      sh   <= '0;
      left <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (left != '0) begin
          txd  <= sh[0];
          sh   <= sh >> 1;
          left <= left - 1'b1;
        end else if (have) begin
          txd  <= ld_data[0];
          sh   <= ld_data >> 1;
          left <= CW'(W - 1);
          busy <= 1'b1;
        end else begin
          txd <= 1'b1;
          if (busy) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_en,
  input  logic         cmd_stop,
  input  logic         cmd_restart,
  input  logic         bit_tick,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         txd,
  output logic         frame_done
);
  logic         run, full, empty, take, push;
  logic [W-1:0] head;

  sertx_gate u_gate (
    .clk(clk), .rst(rst), .tx_en(tx_en),
    .cmd_stop(cmd_stop), .cmd_restart(cmd_restart), .run(run)
  );

  assign in_ready = run & ~full;
  assign push     = in_valid & in_ready;

  sertx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(~run), .push(push), .din(in_data),
    .pop(take), .dout(head), .empty(empty), .full(full)
  );

  sertx_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .abort(~run), .tick(bit_tick), .have(~empty),
    .ld_data(head), .take(take), .txd(txd), .done(frame_done)
  );
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic cmd_stop,
  input logic bit_tick,
  input logic in_ready,
  input logic txd,
  input logic frame_done
);
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (txd && !frame_done)); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> (txd && !frame_done)); // R7
  AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (rst)
    (!tx_en || cmd_stop) |-> !in_ready); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> txd); // R4
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && tx_en && !cmd_stop) |=> $stable(txd)); // R2
endmodule

bind sertx_core sertx_core_chk u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .cmd_stop(cmd_stop),
  .bit_tick(bit_tick), .in_ready(in_ready), .txd(txd), .frame_done(frame_done)
);

// File: tb/sertx_core_test.sv
module sertx_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b1;
  logic       cmd_stop = 1'b0;
  logic       cmd_restart = 1'b0;
  logic       bit_tick = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready, txd, frame_done;
  int         n_run = 0;
  int         n_fail = 0;

  sertx_core uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cmd_stop(cmd_stop),
    .cmd_restart(cmd_restart), .bit_tick(bit_tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .frame_done(frame_done)
  );

  always #2 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    bit_tick = 1'b1;
    cyc();
    bit_tick = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    cyc();
    in_valid = 1'b0;
  endtask

  // send one byte's worth of ticks, gather the line, expect no early done
  task automatic grab(output logic [7:0] got, output logic early);
    early = 1'b0;
    for (int k = 0; k < 8; k++) begin
      tick();
      got[k] = txd;
      if (frame_done) early = 1'b1;
    end
  endtask

  // ticks on an aborted line: count low bits and done pulses
  task automatic quiet(input int n, output int lows, output int dones);
    lows = 0;
    dones = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (!txd) lows++;
      if (frame_done) dones++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       early;
    int         lows, dones;
    logic [7:0] seq [4];
    seq[0] = 8'hA5; seq[1] = 8'h3C; seq[2] = 8'hF0; seq[3] = 8'h01;

    @(negedge clk);
    check(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    cyc(); cyc();
    rst = 1'b0;
    cyc();
    check(txd === 1'b1 && frame_done === 1'b0, "R1 idle after reset", int'({txd, frame_done}), 2);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R3: ticks with nothing queued
    quiet(5, lows, dones);
    check(lows == 0 && dones == 0, "R3 idle line high", lows + dones, 0);

    // R2/R4: every byte value
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      grab(got, early);
      check(got == 8'(b) && !early, "R2 lsb-first bits", int'(got), b);
      tick();
      check(txd === 1'b1 && frame_done === 1'b1, "R4 done with idle line", int'({txd, frame_done}), 3);
      cyc();
      check(frame_done === 1'b0, "R4 done one cycle", int'(frame_done), 0);
    end

    // R5/R9/R4: fill the store, offer one more, send back to back
    for (int i = 0; i < 4; i++) push(seq[i]);
    check(in_ready === 1'b0, "R5 ready low when full", int'(in_ready), 0);
    push(8'h00);
    for (int i = 0; i < 4; i++) begin
      grab(got, early);
      check(got == seq[i] && !early, "R4 back to back no done", int'(got), int'(seq[i]));
    end
    tick();
    check(frame_done === 1'b1, "R4 done after run", int'(frame_done), 1);
    quiet(10, lows, dones);
    check(lows == 0, "R9 byte offered while full dropped", lows, 0);

    // R6: disable mid-byte without a tick
    push(8'h00); push(8'h00);
    tick(); tick(); tick();
    check(txd === 1'b0, "R2 mid-byte low", int'(txd), 0);
    tx_en = 1'b0;
    cyc();
    check(txd === 1'b1 && in_ready === 1'b0, "R6 flush without tick", int'({txd, in_ready}), 2);
    push(8'h00);
    tx_en = 1'b1;
    cyc();
    check(in_ready === 1'b1, "R6 ready back after enable", int'(in_ready), 1);
    quiet(20, lows, dones);
    check(lows == 0 && dones == 0, "R6 leftover bits never sent", lows + dones, 0);
    check(lows == 0, "R9 byte offered while disabled dropped", lows, 0);

    // R7: halt command mid-byte
    push(8'h00);
    tick(); tick();
    cmd_stop = 1'b1;
    #1;
    check(in_ready === 1'b0, "R5 ready low with halt command", int'(in_ready), 0);
    cyc();
    cmd_stop = 1'b0;
    check(txd === 1'b1 && in_ready === 1'b0, "R7 halt aborts", int'({txd, in_ready}), 2);
    push(8'h00);
    quiet(12, lows, dones);
    check(lows == 0 && dones == 0, "R7 halted line idle", lows + dones, 0);
    tx_en = 1'b0; cyc(); tx_en = 1'b1; cyc();
    check(in_ready === 1'b0, "R7 halt survives enable toggle", int'(in_ready), 0);

    // R8: simultaneous commands keep the halt
    cmd_stop = 1'b1; cmd_restart = 1'b1;
    cyc();
    cmd_stop = 1'b0; cmd_restart = 1'b0;
    cyc();
    check(in_ready === 1'b0, "R8 halt wins over resume", int'(in_ready), 0);
    cmd_restart = 1'b1;
    cyc();
    cmd_restart = 1'b0;
    check(in_ready === 1'b1, "R8 resume reopens", int'(in_ready), 1);
    push(8'h5A);
    grab(got, early);
    check(got == 8'h5A && !early, "R8 sends after resume", int'(got), 90);
    tick();
    check(frame_done === 1'b1, "R8 done after resume", int'(frame_done), 1);

    // R8: resume with enable low, then enable
    cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
    tx_en = 1'b0;
    cmd_restart = 1'b1; cyc(); cmd_restart = 1'b0;
    check(in_ready === 1'b0, "R8 needs enable too", int'(in_ready), 0);
    tx_en = 1'b1;
    #1;
    check(in_ready === 1'b1, "R8 resumes once enabled", int'(in_ready), 1);
    cyc();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule